// File: doc/BRIEF.md
# Full-Adder Population Counter

This block counts the set bits of one 64-bit word and returns a 7-bit count from 0 to 64. It is built only from full-adder cells. Each cell takes three bits of equal weight and returns a sum bit of weight one and a carry bit of weight two. Its carry input is used as a plain third data bit; no carry propagates between cells.

The cells form a recursive tree. A count over 2^k-1 bits is made from two counts over 2^(k-1)-1 bits and one spare input bit. The spare bit enters a ripple rank of k-1 full adders as its carry input, and that rank merges the two narrower counts. The smallest case is three bits, which is a single cell. With this scheme the lower 63 bits of the word use 57 cells. One more ripple rank of six cells then folds in the 64th bit and gives the 7-bit result.

The result is registered by default, so it has one cycle of latency and a new word can be given on every cycle. Setting a parameter removes the register and leaves a purely combinational counter.

Top module: `popcnt64`

## Requirements
- R1: For any 64-bit operand, the count equals the number of bits set to 1 in that operand.
- R2: An all-zero operand gives a count of 0.
- R3: An all-ones operand gives exactly 64, which is bit 6 of the count set and bits 5..0 clear.
- R4: An operand with exactly one bit set gives a count of 1, whichever of the 64 positions holds that bit.
- R5: The count never exceeds 64.
- R6: With the output register enabled (the default), the count changes only on a rising clock edge. It then shows the count of the operand that was present at that edge, and a new operand is accepted on every cycle.
- R7: Driving the active-low reset low clears the count to 0 without waiting for a clock edge, and the count stays 0 while reset is held.
- R8: The alternating operands 0x5555_5555_5555_5555 and 0xAAAA_AAAA_AAAA_AAAA each give 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| operand | input | 64 | Word whose set bits are counted |
| count | output | 7 | Number of set bits, 0 to 64 |

## Verification
A cell that is miswired or missing changes the count only when its own input bits are set. Because of that, each input position is exercised alone, and the all-ones word is applied to drive every carry through every rank. Each such fault appears at `count` on the cycle right after the offending word is applied, as a result off by a power of two. Random and alternating words then catch faults that show up only when several ranks carry at once. Operands applied back to back show whether the register drops or repeats a result.

// File: rtl/popcnt_pkg.sv
package popcnt_pkg;

  // First operand bit used as a spare input by the merge nodes of a level.
  // Leaves use the lowest 3*2^(logW-2) bits; each later level takes the
  // next 2^(logW-level) bits; the top bit is left for the final rank.
  function automatic int spareBase(input int logW, input int level);
    return (1 << logW) - (1 << (logW - level + 1));
  endfunction

endpackage

// File: rtl/pcFullAdder.sv
module pcFullAdder (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic sum,
  output logic carry
);
  assign sum   = x ^ y ^ z;
  assign carry = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/pcRippleRank.sv
module pcRippleRank #(
  parameter int IN_W = 2
) (
  input  logic [IN_W-1:0] a,
  input  logic [IN_W-1:0] b,
  input  logic            cin,
  output logic [IN_W:0]   total
);
  logic [IN_W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < IN_W; i++) begin : gCell
    pcFullAdder uCell (
      .x    (a[i]),
      .y    (b[i]),
      .z    (chain[i]),
      .sum  (total[i]),
      .carry(chain[i+1])
    );
  end

  assign total[IN_W] = chain[IN_W];
endmodule

// File: rtl/pcCompressTree.sv
module pcCompressTree
  import popcnt_pkg::*;
#(
  parameter int LOG_W = 6,
  localparam int IN_W = (1 << LOG_W) - 1
) (
  input  logic [IN_W-1:0]  bits,
  output logic [LOG_W-1:0] partial
);
  for (genvar lv = 2; lv <= LOG_W; lv++) begin : gLvl
    localparam int NODES = 1 << (LOG_W - lv);
    logic [NODES-1:0][lv-1:0] nodeSum;

    if (lv == 2) begin : gLeaf
      for (genvar j = 0; j < NODES; j++) begin : gNode
        pcFullAdder uLeaf (
          .x    (bits[3*j]),
          .y    (bits[3*j+1]),
          .z    (bits[3*j+2]),
          .sum  (nodeSum[j][0]),
          .carry(nodeSum[j][1])
        );
      end
    end else begin : gMerge
      localparam int SPARE = spareBase(LOG_W, lv);
      for (genvar j = 0; j < NODES; j++) begin : gNode
        pcRippleRank #(.IN_W(lv - 1)) uMerge (
          .a    (gLvl[lv-1].nodeSum[2*j]),
          .b    (gLvl[lv-1].nodeSum[2*j+1]),
          .cin  (bits[SPARE+j]),
          .total(nodeSum[j])
        );
      end
    end
  end

  assign partial = gLvl[LOG_W].nodeSum[0];
endmodule

// File: rtl/pcOutStage.sv
module pcOutStage #(
  parameter int W       = 7,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] nextCount,
  output logic [W-1:0] count
);
  if (REG_OUT) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) count <= '0;
      else       count <= nextCount;
    end
  end else begin : gComb
    assign count = nextCount;
  end
endmodule

// File: rtl/popcnt64.sv
module popcnt64 #(
  parameter int LOG_W   = 6,
  parameter bit REG_OUT = 1'b1,
  localparam int DATA_W = 1 << LOG_W,
  localparam int CNT_W  = LOG_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] operand,
  output logic [CNT_W-1:0]  count
);
  logic [LOG_W-1:0] lowCount;
  logic [CNT_W-1:0] fullCount;

  pcCompressTree #(.LOG_W(LOG_W)) uTree (
    .bits   (operand[DATA_W-2:0]),
    .partial(lowCount)
  );

  pcRippleRank #(.IN_W(LOG_W)) uFinal (
    .a    (lowCount),
    .b    ('0),
    .cin  (operand[DATA_W-1]),
    .total(fullCount)
  );

  pcOutStage #(.W(CNT_W), .REG_OUT(REG_OUT)) uOut (
    .clk      (clk),
    .rstN     (rstN),
    .nextCount(fullCount),
    .count    (count)
  );
endmodule

// File: rtl/popcnt64_chk.sv
module popcnt64_chk #(
  parameter int LOG_W   = 6,
  parameter bit REG_OUT = 1'b1,
  localparam int DATA_W = 1 << LOG_W,
  localparam int CNT_W  = LOG_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] operand,
  input logic [CNT_W-1:0]  count
);
  assert_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DATA_W));

  assert_top_weight_R3: assert property (@(posedge clk) disable iff (!rstN)
    count[CNT_W-1] |-> (count[CNT_W-2:0] == '0));

  if (REG_OUT) begin : gRegChk
    assert_count_matches_R1: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> (count == CNT_W'($countones($past(operand)))));

    assert_all_ones_R3: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && (&$past(operand))) |-> (count == CNT_W'(DATA_W)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(rstN, 2) && ($past(operand, 2) == $past(operand)))
      |-> $stable(count));

    assert_reset_clear_R7: assert property (@(posedge clk)
      !rstN |-> (count == '0));
  end else begin : gCombChk
    always_comb begin
      if (rstN) assert_comb_match_R1: assert (count == CNT_W'($countones(operand)));
    end
  end
endmodule

bind popcnt64 popcnt64_chk #(.LOG_W(LOG_W), .REG_OUT(REG_OUT)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .operand(operand),
  .count  (count)
);

// File: tb/popcnt64_tb.sv
module popcnt64_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic [63:0] operand = '0;
  logic [6:0]  count;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [6:0] expQ[$];
  string      tagQ[$];

  popcnt64 u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .operand(operand),
    .count  (count)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [6:0] refCount(input logic [63:0] w);
    int n = 0;
    for (int i = 0; i < 64; i++) if (w[i]) n++;
    return 7'(n);
  endfunction

  task automatic check(input logic [6:0] actual, input logic [6:0] expected, input string tag);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: count=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic drive(input logic [63:0] w, input string tag);
    @(negedge clk);
    operand = w;
    expQ.push_back(refCount(w));
    tagQ.push_back(tag);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(posedge clk);
    #2;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor: a word driven at a falling edge is captured at the next rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() != 0) begin
        logic [6:0] e;
        string      t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(count, e, t);
        checks++;
        if (count > 7'd64) begin
          errors++;
          $display("FAIL R5: count=%0d expected<=64", count);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: count=%0d expected=completion", count);
    finishRun();
  end

  initial begin
    #1 rstN = 1'b0;
    #1 check(count, 7'd0, "R7 async clear");
    repeat (3) @(posedge clk);
    #1 check(count, 7'd0, "R7 held in reset");
    @(negedge clk);
    rstN = 1'b1;

    drive(64'h0, "R2 zero");
    drive({64{1'b1}}, "R3 all ones");
    drive(64'h5555_5555_5555_5555, "R8 alternating 5");
    drive(64'hAAAA_AAAA_AAAA_AAAA, "R8 alternating A");
    for (int i = 0; i < 64; i++) drive(64'h1 << i, "R4 single bit");
    for (int i = 0; i < 63; i++) drive({64{1'b1}} >> i, "R1 descending runs");
    for (int i = 0; i < 300; i++) drive({$urandom(), $urandom()}, "R1 random");
    drive(64'h0, "R2 zero after traffic");
    drain();

    // R6: a new operand does not reach the output before the next rising edge.
    @(negedge clk);
    operand = {64{1'b1}};
    #1 check(count, 7'd0, "R6 stable before edge");
    @(posedge clk);
    #1 check(count, 7'd64, "R6 updated after edge");

    // R7: reset in mid-run clears without a clock edge and holds.
    @(negedge clk);
    rstN = 1'b0;
    #1 check(count, 7'd0, "R7 mid-run clear");
    @(posedge clk);
    #1 check(count, 7'd0, "R7 mid-run hold");
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1 check(count, 7'd64, "R6 resumes after reset");

    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule